// File: doc/BRIEF.md
# Programmable Watchdog Timer with Time-Unit Select

This block is a system watchdog. Software arms it by writing a nonzero timeout into its count register. From then on the count falls by one every time unit. When the count reaches zero, a reset pulse of fixed length is issued on `wdt_rst_o`. Software keeps the system alive by writing the count register again before expiry. Writing zero stops the watchdog at once and issues no reset. Reading the count register returns the live remaining count.

A one-millisecond tick input drives an internal prescaler. The prescaler produces either a one-second or a one-minute unit tick, chosen by a control bit. Keyboard and mouse interrupt pulses can be allowed to reload the count, each with its own enable bit. Host bus decoding and pin multiplexing sit in a wrapper. This block sees only a flat byte-wide register port with a two-bit address.

Top module: `wdt_top`

## Requirements
- R1: After reset, the count register reads 0x00, `active_o` is 0 and `wdt_rst_o` is 0.
- R2: Writing a value from 1 to 255 to address 0 (count register) arms the watchdog. From the next cycle the count reads that value and `active_o` is 1.
- R3: While armed in seconds mode, the count falls by exactly one after every TICKS_PER_SEC millisecond ticks. The prescaler restarts on every count write and on every effective reload, so the first period is always a full one.
- R4: When the count falls from 1 to 0, the count reads 0 and `active_o` drops in that same cycle. `wdt_rst_o` is high for exactly RST_PULSE_CYCLES cycles, starting in that cycle. The count then stays 0 until software writes it.
- R5: Writing 0x00 to address 0 disarms the watchdog in the next cycle: the count reads 0 and `active_o` is 0, and no reset pulse is issued at that time or later.
- R6: Writing 0x00 and then a timeout value restarts the countdown from that value (refresh). Writing a new nonzero value while armed has the same effect.
- R7: Bit 3 of address 1 (control register) selects the unit: 0 means seconds, 1 means minutes. In minutes mode the count falls once every TICKS_PER_SEC*SEC_PER_MIN millisecond ticks.
- R8: In address 2, bit 7 enables keyboard reloads and bit 6 enables mouse reloads. While armed, an enabled event pulse reloads the count with the last value written and restarts the prescaler. This reload takes priority over a unit tick in the same cycle. An event whose enable bit is 0 has no effect.
- R9: A count-register write that lands in the same cycle as a unit tick wins. The count takes the written value and is not decremented.
- R10: While disarmed, event pulses do not arm the watchdog and do not change the count, even when their enable bits are set.
- R11: Address 1 reads back only bit 3 and address 2 reads back only bits 7:6. All other bits read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse once per millisecond |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 count, 1 control, 2 event enables |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i`, combinational |
| kbd_evt_i | input | 1 | Keyboard interrupt event pulse |
| mouse_evt_i | input | 1 | Mouse interrupt event pulse |
| wdt_rst_o | output | 1 | System reset pulse |
| active_o | output | 1 | Watchdog armed and counting |

## Verification
Two pairs of functions can land in one cycle. The first pair is a count-register write and a unit tick. The second is an enabled event reload and a unit tick. The bench provokes each by holding the millisecond tick high every cycle and counting clock edges from the last write. This lets it place the write, or the event pulse, exactly on the edge where the prescaler wraps. It then judges the outcome from the count read back: the written or reloaded value must appear, never that value minus one. The next decrement must come only after a full unit period, which shows that the prescaler was restarted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_EVT   = 2'd2
  } wdt_reg_e;

  localparam int UNIT_BIT  = 3;
  localparam int KBD_BIT   = 7;
  localparam int MOUSE_BIT = 6;

  typedef struct packed {
    logic kbd;
    logic mouse;
  } evt_en_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SEC_PER_MIN   = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  input  logic unit_min_i,
  input  logic ms_tick_i,
  output logic unit_tick_o
);
  localparam int MS_W  = $clog2(TICKS_PER_SEC + 1);
  localparam int SEC_W = $clog2(SEC_PER_MIN + 1);
  localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(TICKS_PER_SEC - 1);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);

  logic [MS_W-1:0]  ms_cnt_q;
  logic [SEC_W-1:0] sec_cnt_q;
  logic             hold;
  logic             sec_pulse;

  assign hold      = !run_i || clear_i;
  assign sec_pulse = !hold && ms_tick_i && (ms_cnt_q == MS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ms_cnt_q <= '0;
    end else if (hold) begin
      ms_cnt_q <= '0;
    end else if (ms_tick_i) begin
      ms_cnt_q <= (ms_cnt_q == MS_LAST) ? '0 : ms_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cnt_q <= '0;
    end else if (hold || !unit_min_i) begin
      sec_cnt_q <= '0;
    end else if (sec_pulse) begin
      sec_cnt_q <= (sec_cnt_q == SEC_LAST) ? '0 : sec_cnt_q + 1'b1;
    end
  end

  assign unit_tick_o = unit_min_i ? (sec_pulse && (sec_cnt_q == SEC_LAST)) : sec_pulse;

  // R3
  tick_needs_ms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_tick_o |-> (ms_tick_i && run_i && !clear_i));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reload_i,
  input  logic             unit_tick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             active_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] last_q;
  logic             active_q;

  // priority: register write, then event reload, then unit tick
  assign expire_o = active_q && !load_i && !reload_i && unit_tick_i &&
                    (count_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q  <= '0;
      last_q   <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      count_q  <= load_val_i;
      last_q   <= load_val_i;
      active_q <= (load_val_i != '0);
    end else if (active_q && reload_i) begin
      count_q <= last_q;
    end else if (active_q && unit_tick_i) begin
      count_q <= count_q - 1'b1;
      if (count_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end

  assign count_o  = count_q;
  assign active_o = active_q;

  // R2
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> (active_o && count_o == $past(load_val_i)));
  // R5
  stop_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i == '0) |=> (!active_o && count_o == '0));
  // R3
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && unit_tick_i && !load_i && !reload_i && count_o > CNT_W'(1))
    |=> (active_o && count_o == $past(count_o) - 1'b1));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !load_i) |=> (count_o == $past(count_o) && !active_o));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trigger_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (trigger_i) begin
      left_q <= PW'(PULSE_CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = (left_q != '0);

  // R4
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_i |=> pulse_o);
  // R4
  pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(trigger_i));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC    = 1000,
  parameter int SEC_PER_MIN      = 60,
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              kbd_evt_i,
  input  logic              mouse_evt_i,
  output logic              wdt_rst_o,
  output logic              active_o
);
  logic              unit_min_q;
  evt_en_t           evt_en_q;
  logic              cnt_wr;
  logic              evt_hit;
  logic              reload;
  logic              unit_tick;
  logic              expire;
  logic              active;
  logic [DATA_W-1:0] count;

  assign cnt_wr  = reg_we_i && (reg_addr_i == REG_COUNT);
  assign evt_hit = (kbd_evt_i && evt_en_q.kbd) || (mouse_evt_i && evt_en_q.mouse);
  assign reload  = evt_hit && active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_min_q <= 1'b0;
      evt_en_q   <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == REG_CTRL) unit_min_q <= reg_wdata_i[UNIT_BIT];
      if (reg_addr_i == REG_EVT) begin
        evt_en_q.kbd   <= reg_wdata_i[KBD_BIT];
        evt_en_q.mouse <= reg_wdata_i[MOUSE_BIT];
      end
    end
  end

  wdt_prescaler #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .SEC_PER_MIN  (SEC_PER_MIN)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (active),
    .clear_i    (cnt_wr || reload),
    .unit_min_i (unit_min_q),
    .ms_tick_i  (ms_tick_i),
    .unit_tick_o(unit_tick)
  );

  wdt_counter #(
    .CNT_W(DATA_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_wr),
    .load_val_i (reg_wdata_i),
    .reload_i   (reload),
    .unit_tick_i(unit_tick),
    .count_o    (count),
    .active_o   (active),
    .expire_o   (expire)
  );

  wdt_rst_pulse #(
    .PULSE_CYCLES(RST_PULSE_CYCLES)
  ) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .trigger_i(expire),
    .pulse_o  (wdt_rst_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_COUNT: reg_rdata_o = count;
      REG_CTRL:  reg_rdata_o[UNIT_BIT] = unit_min_q;
      REG_EVT: begin
        reg_rdata_o[KBD_BIT]   = evt_en_q.kbd;
        reg_rdata_o[MOUSE_BIT] = evt_en_q.mouse;
      end
      default:   reg_rdata_o = '0;
    endcase
  end

  assign active_o = active;

  // R10
  idle_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !cnt_wr) |=> !active_o);
  // R9
  write_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> (count == $past(reg_wdata_i)));
  // R5
  no_rst_on_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_wr && reg_wdata_i == '0) |=> !$rose(wdt_rst_o));
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int TPS   = 4;
  localparam int SPM   = 3;
  localparam int PULSE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       kbd = 1'b0;
  logic       mouse = 1'b0;
  logic       wdt_rst;
  logic       active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdt_top #(
    .TICKS_PER_SEC   (TPS),
    .SEC_PER_MIN     (SPM),
    .RST_PULSE_CYCLES(PULSE)
  ) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ms_tick_i  (ms_tick),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .kbd_evt_i  (kbd),
    .mouse_evt_i(mouse),
    .wdt_rst_o  (wdt_rst),
    .active_o   (active)
  );

  typedef struct {
    string      req;
    logic [7:0] val;
    bit         st;
    logic       act;
    logic       rst;
  } exp_t;

  exp_t exp_q[$];

  // monitor: pops one expected item per negedge and compares
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      checks++;
      if (rdata !== it.val || (it.st && (active !== it.act || wdt_rst !== it.rst))) begin
        errors++;
        $display("FAIL %s: rdata=%h act=%b rst=%b expected rdata=%h act=%b rst=%b",
                 it.req, rdata, active, wdt_rst, it.val, it.act, it.rst);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0; addr = 2'd0;
  endtask

  task automatic evt(input logic k, input logic m);
    kbd = k; mouse = m;
    step(1);
    kbd = 1'b0; mouse = 1'b0;
  endtask

  task automatic exp_st(input string r, input logic [7:0] c, input logic a, input logic rs);
    exp_t it;
    addr = 2'd0;
    it.req = r; it.val = c; it.st = 1'b1; it.act = a; it.rst = rs;
    exp_q.push_back(it);
    @(negedge clk);
    #1;
  endtask

  task automatic exp_reg(input string r, input logic [1:0] a, input logic [7:0] v);
    exp_t it;
    addr = a;
    it.req = r; it.val = v; it.st = 1'b0; it.act = 1'b0; it.rst = 1'b0;
    exp_q.push_back(it);
    @(negedge clk);
    #1;
    addr = 2'd0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    exp_st("R1", 8'd0, 1'b0, 1'b0);
    ms_tick = 1'b1;

    // R11 register readback
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hFF);
    exp_reg("R11", 2'd1, 8'h08);
    exp_reg("R11", 2'd2, 8'hC0);
    exp_reg("R11", 2'd3, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h00);

    // R10 events while disarmed
    wr(2'd2, 8'hC0);
    evt(1'b1, 1'b1);
    exp_st("R10", 8'd0, 1'b0, 1'b0);
    wr(2'd2, 8'h00);

    // R2 / R3 arm and count in seconds
    wr(2'd0, 8'd5);
    exp_st("R2", 8'd5, 1'b1, 1'b0);
    step(3);
    exp_st("R3", 8'd5, 1'b1, 1'b0);
    step(1);
    exp_st("R3", 8'd4, 1'b1, 1'b0);
    step(4);
    exp_st("R3", 8'd3, 1'b1, 1'b0);

    // R9 write on the tick edge
    step(3);
    wr(2'd0, 8'd9);
    exp_st("R9", 8'd9, 1'b1, 1'b0);
    step(3);
    exp_st("R9", 8'd9, 1'b1, 1'b0);
    step(1);
    exp_st("R9", 8'd8, 1'b1, 1'b0);

    // R5 stop
    wr(2'd0, 8'd0);
    exp_st("R5", 8'd0, 1'b0, 1'b0);
    step(6);
    exp_st("R5", 8'd0, 1'b0, 1'b0);

    // R6 refresh
    wr(2'd0, 8'd5);
    step(4);
    exp_st("R6", 8'd4, 1'b1, 1'b0);
    wr(2'd0, 8'd0);
    wr(2'd0, 8'd5);
    exp_st("R6", 8'd5, 1'b1, 1'b0);
    step(3);
    exp_st("R6", 8'd5, 1'b1, 1'b0);
    step(1);
    exp_st("R6", 8'd4, 1'b1, 1'b0);

    // R4 expiry
    wr(2'd0, 8'd0);
    wr(2'd0, 8'd2);
    step(7);
    exp_st("R4", 8'd1, 1'b1, 1'b0);
    step(1);
    exp_st("R4", 8'd0, 1'b0, 1'b1);
    step(2);
    exp_st("R4", 8'd0, 1'b0, 1'b1);
    step(1);
    exp_st("R4", 8'd0, 1'b0, 1'b0);
    step(5);
    exp_st("R4", 8'd0, 1'b0, 1'b0);

    // R7 minutes
    wr(2'd1, 8'h08);
    wr(2'd0, 8'd2);
    step(11);
    exp_st("R7", 8'd2, 1'b1, 1'b0);
    step(1);
    exp_st("R7", 8'd1, 1'b1, 1'b0);
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h00);

    // R8 keyboard enabled only
    wr(2'd2, 8'h80);
    wr(2'd0, 8'd6);
    step(3);
    evt(1'b0, 1'b1);
    exp_st("R8", 8'd5, 1'b1, 1'b0);
    evt(1'b1, 1'b0);
    exp_st("R8", 8'd6, 1'b1, 1'b0);
    step(3);
    exp_st("R8", 8'd6, 1'b1, 1'b0);
    step(1);
    exp_st("R8", 8'd5, 1'b1, 1'b0);
    wr(2'd0, 8'd0);

    // R8 mouse enabled, reload on the tick edge
    wr(2'd2, 8'h40);
    wr(2'd0, 8'd6);
    step(3);
    evt(1'b0, 1'b1);
    exp_st("R8", 8'd6, 1'b1, 1'b0);
    step(3);
    exp_st("R8", 8'd6, 1'b1, 1'b0);
    step(1);
    exp_st("R8", 8'd5, 1'b1, 1'b0);
    wr(2'd0, 8'd0);

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule